// File: doc/BRIEF.md
# Banked Memory Pattern Test Sequencer

This block is a built-in self-test engine for a word-addressed memory that is split into equal banks. A start pulse latches how many banks are populated. The sequencer then sweeps every word of those banks five times. In each sweep it reads the word, compares it with the value the previous sweep left there, and writes the next pattern into it. The first sweep expects a fixed seed value that software or an earlier stage has already written everywhere.

Because the expected value is always the previous sweep's pattern, a write that lands on the wrong word shows up as a miscompare later in the same sweep. The last sweep writes zero, so a successful run leaves the tested memory cleared. The block stops at the first miscompare, or when the memory reports an error, and it records the failing address and sweep index. The result stays on the outputs until the next start.

Top module: `mbist_seq`

## Requirements
- R1: While reset is high and after it is released, busy, done, fail and mem_req are 0, fail_code is 0 and fail_addr and fail_pass are 0.
- R2: A start pulse while busy is 0 latches bank_cnt, clears the result outputs and begins sweep 0 at address 0, expecting 0x3C3C. A start pulse while busy is 1 is ignored. Changes on bank_cnt while busy are ignored.
- R3: Each word takes two cycles: a read cycle (mem_req=1, mem_we=0), then a compare cycle in which mem_rdata (valid one cycle after the read request) is compared and, on a match, the new pattern is written to the same address (mem_req=1, mem_we=1).
- R4: Sweeps 0 to 4 write 0xC3C3, 0x0000, 0xFFFF, 0x0001 and 0x0000 in that order. Sweep p for p≥1 expects the value written by sweep p-1.
- R5: mem_addr is {bank, offset}, with the offset in the low OFF_W bits. The offset counts up from 0, and its carry moves the sequencer to the next bank. A sweep ends after the last word of bank bank_cnt-1, and no access ever touches a bank at or above the latched count.
- R6: With no fault, done rises exactly 10·bank_cnt·2^OFF_W clock edges after the start edge, busy falls, fail stays 0 with fail_code 0, and every tested word holds 0x0000.
- R7: On a miscompare the compare cycle issues no write. The sequencer enters done at the next edge with fail=1, fail_code=1, fail_addr equal to the failing address and fail_pass equal to the sweep index (0 to 4).
- R8: mem_err high in any busy cycle aborts at that edge with fail=1 and fail_code=2, recording the current address and sweep. In a compare cycle it suppresses the write and takes priority over a miscompare.
- R9: While busy is 0, mem_req stays 0. done, fail, fail_code, fail_addr and fail_pass hold their values until the next accepted start.
- R10: A start with bank_cnt=0 makes no memory access and shows done=1, fail=0 after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only while not busy |
| bank_cnt | input | BANK_W | Number of populated banks, latched at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request (0 = read) |
| mem_addr | output | BANK_W+OFF_W | Word address {bank, offset} |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| mem_err | input | 1 | Memory error flag, aborts the test |
| busy | output | 1 | Test sweep in progress |
| done | output | 1 | Test finished, result valid |
| fail | output | 1 | Test failed |
| fail_code | output | 2 | 0 none, 1 miscompare, 2 memory error |
| fail_addr | output | BANK_W+OFF_W | Address at which the test stopped |
| fail_pass | output | 3 | Sweep index in which the test stopped |

## Verification
Every result has a fixed due time measured in edges from the start edge. A clean run finishes at 10·W edges, where W is the word count. A miscompare at word g of the whole run finishes at edge 2g+2. An error sampled at edge c finishes at edge c, and a zero-bank start finishes at edge 0. The bench counts negedges from the start edge until done appears and compares that count with the computed value, so a result that arrives one cycle early or late is caught. Each write is checked at the negedge of its own cycle against the address and pattern that the running write count predicts.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int MB_DW     = 16;
    localparam int MB_PASSES = 5;
    localparam int MB_PASS_W = 3;

    typedef logic [MB_DW-1:0]     mb_word_t;
    typedef logic [MB_PASS_W-1:0] mb_pass_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CMP  = 2'd2,
        ST_DONE = 2'd3
    } mb_state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_MISMATCH = 2'd1,
        FC_EXT_ERR  = 2'd2
    } mb_fail_e;

    typedef struct packed {
        logic     fail;
        mb_fail_e code;
        mb_pass_t pass;
    } mb_result_t;

    localparam mb_word_t MB_SEED = 16'h3C3C;

    function automatic mb_word_t mb_pattern(input mb_pass_t p);
        case (p)
            3'd0:    return 16'hC3C3;
            3'd1:    return 16'h0000;
            3'd2:    return 16'hFFFF;
            3'd3:    return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic mb_is_final(input mb_pass_t p);
        return p == mb_pass_t'(MB_PASSES - 1);
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int OFF_W  = 16,
    parameter int BANK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    restart,
    input  logic                    step,
    input  logic [BANK_W-1:0]       bank_lim_in,
    output logic [BANK_W+OFF_W-1:0] addr,
    output logic                    last_word
);
    localparam int ADDR_W = BANK_W + OFF_W;

    logic [OFF_W-1:0]  off_q;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] lim_q;
    logic [OFF_W:0]    off_inc;
    logic              off_carry;

    assign off_inc   = {1'b0, off_q} + {{OFF_W{1'b0}}, 1'b1};
    assign off_carry = off_inc[OFF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            bank_q <= '0;
            lim_q  <= '0;
        end else if (clear) begin
            off_q  <= '0;
            bank_q <= '0;
            lim_q  <= bank_lim_in;
        end else if (restart) begin
            off_q  <= '0;
            bank_q <= '0;
        end else if (step) begin
            off_q <= off_inc[OFF_W-1:0];
            if (off_carry) begin
                bank_q <= bank_q + {{(BANK_W-1){1'b0}}, 1'b1};
            end
        end
    end

    assign addr      = ADDR_W'({bank_q, off_q});
    assign last_word = off_carry && (bank_q == BANK_W'(lim_q - {{(BANK_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/mbist_pattern_gen.sv
module mbist_pattern_gen
    import mbist_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     advance,
    output mb_pass_t pass_idx,
    output mb_word_t wr_pattern,
    output mb_word_t expected,
    output logic     final_pass
);
    mb_pass_t pass_q;
    mb_word_t exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_q <= '0;
            exp_q  <= MB_SEED;
        end else if (clear) begin
            pass_q <= '0;
            exp_q  <= MB_SEED;
        end else if (advance) begin
            pass_q <= pass_q + mb_pass_t'(1);
            exp_q  <= mb_pattern(pass_q);
        end
    end

    assign pass_idx   = pass_q;
    assign wr_pattern = mb_pattern(pass_q);
    assign expected   = exp_q;
    assign final_pass = mb_is_final(pass_q);

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              no_banks,
    input  logic              match,
    input  logic              last_word,
    input  logic              final_pass,
    input  logic              mem_err,
    input  logic [ADDR_W-1:0] cur_addr,
    input  mb_pass_t          cur_pass,
    output logic              ag_clear,
    output logic              ag_restart,
    output logic              ag_step,
    output logic              pg_clear,
    output logic              pg_adv,
    output logic              req,
    output logic              we,
    output logic              busy,
    output logic              done,
    output mb_result_t        result,
    output logic [ADDR_W-1:0] fail_addr
);
    mb_state_e         st_q;
    mb_state_e         st_d;
    mb_result_t        res_q;
    logic [ADDR_W-1:0] faddr_q;

    logic start_ok;
    logic in_rd;
    logic in_cmp;
    logic wr_ok;
    logic pass_end;
    logic run_end;
    logic abort_err;
    logic abort_mis;

    assign in_rd     = (st_q == ST_RD);
    assign in_cmp    = (st_q == ST_CMP);
    assign start_ok  = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
    assign abort_err = (in_rd || in_cmp) && mem_err;
    assign abort_mis = in_cmp && !mem_err && !match;
    assign wr_ok     = in_cmp && !mem_err && match;
    assign pass_end  = wr_ok && last_word && !final_pass;
    assign run_end   = wr_ok && last_word && final_pass;

    assign ag_clear   = start_ok;
    assign pg_clear   = start_ok;
    assign ag_step    = wr_ok && !last_word;
    assign ag_restart = pass_end;
    assign pg_adv     = pass_end;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start_ok) begin
                    st_d = no_banks ? ST_DONE : ST_RD;
                end
            end
            ST_RD: begin
                st_d = abort_err ? ST_DONE : ST_CMP;
            end
            ST_CMP: begin
                if (abort_err || abort_mis || run_end) begin
                    st_d = ST_DONE;
                end else begin
                    st_d = ST_RD;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            res_q   <= '{fail: 1'b0, code: FC_NONE, pass: '0};
            faddr_q <= '0;
        end else begin
            st_q <= st_d;
            if (start_ok) begin
                res_q   <= '{fail: 1'b0, code: FC_NONE, pass: '0};
                faddr_q <= '0;
            end else if (abort_err) begin
                res_q   <= '{fail: 1'b1, code: FC_EXT_ERR, pass: cur_pass};
                faddr_q <= cur_addr;
            end else if (abort_mis) begin
                res_q   <= '{fail: 1'b1, code: FC_MISMATCH, pass: cur_pass};
                faddr_q <= cur_addr;
            end
        end
    end

    assign req       = in_rd || wr_ok;
    assign we        = wr_ok;
    assign busy      = in_rd || in_cmp;
    assign done      = (st_q == ST_DONE);
    assign result    = res_q;
    assign fail_addr = faddr_q;

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int BANK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [BANK_W-1:0]       bank_cnt,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [BANK_W+OFF_W-1:0] mem_addr,
    output logic [15:0]             mem_wdata,
    input  logic [15:0]             mem_rdata,
    input  logic                    mem_err,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic [1:0]              fail_code,
    output logic [BANK_W+OFF_W-1:0] fail_addr,
    output logic [2:0]              fail_pass
);
    localparam int ADDR_W = BANK_W + OFF_W;

    logic              ag_clear;
    logic              ag_restart;
    logic              ag_step;
    logic              pg_clear;
    logic              pg_adv;
    logic              last_word;
    logic              final_pass;
    logic              match;
    logic [ADDR_W-1:0] cur_addr;
    mb_pass_t          pass_idx;
    mb_word_t          wr_pattern;
    mb_word_t          expected;
    mb_result_t        result;

    mbist_addr_gen #(
        .OFF_W  (OFF_W),
        .BANK_W (BANK_W)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .clear       (ag_clear),
        .restart     (ag_restart),
        .step        (ag_step),
        .bank_lim_in (bank_cnt),
        .addr        (cur_addr),
        .last_word   (last_word)
    );

    mbist_pattern_gen u_pat (
        .clk        (clk),
        .rst        (rst),
        .clear      (pg_clear),
        .advance    (pg_adv),
        .pass_idx   (pass_idx),
        .wr_pattern (wr_pattern),
        .expected   (expected),
        .final_pass (final_pass)
    );

    assign match = (mem_rdata == expected);

    mbist_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .no_banks   (bank_cnt == '0),
        .match      (match),
        .last_word  (last_word),
        .final_pass (final_pass),
        .mem_err    (mem_err),
        .cur_addr   (cur_addr),
        .cur_pass   (pass_idx),
        .ag_clear   (ag_clear),
        .ag_restart (ag_restart),
        .ag_step    (ag_step),
        .pg_clear   (pg_clear),
        .pg_adv     (pg_adv),
        .req        (mem_req),
        .we         (mem_we),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .fail_addr  (fail_addr)
    );

    assign mem_addr  = cur_addr;
    assign mem_wdata = wr_pattern;
    assign fail      = result.fail;
    assign fail_code = result.code;
    assign fail_pass = result.pass;

endmodule

// File: rtl/mbist_seq_chk.sv
module mbist_seq_chk #(
    parameter int OFF_W  = 16,
    parameter int BANK_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic                    fail,
    input logic [1:0]              fail_code,
    input logic [BANK_W+OFF_W-1:0] fail_addr,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [BANK_W+OFF_W-1:0] mem_addr,
    input logic [15:0]             mem_wdata
);
    AST_WE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(mem_req && !mem_we)) else $error("write without read"); // R3

    AST_WE_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr == $past(mem_addr)) else $error("write address moved"); // R3

    AST_WDATA_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == 16'hC3C3 || mem_wdata == 16'h0000 ||
                    mem_wdata == 16'hFFFF || mem_wdata == 16'h0001)) else $error("bad pattern"); // R4

    AST_END_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done) else $error("busy fell without done"); // R6

    AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (fail_code != 2'd0)) else $error("fail without code"); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req) else $error("access while not busy"); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_code) && $stable(fail_addr)))
        else $error("result moved"); // R9

endmodule

bind mbist_seq mbist_seq_chk #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/mbist_seq_bench.sv
`timescale 1ns/1ps
module mbist_seq_bench;
    localparam int OFF_W  = 4;
    localparam int BANK_W = 3;
    localparam int AW     = OFF_W + BANK_W;
    localparam int WPB    = 1 << OFF_W;
    localparam int DEPTH  = 1 << AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [BANK_W-1:0] bank_cnt = '0;
    logic              mem_req, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata = '0;
    logic              mem_err = 1'b0;
    logic              busy, done, fail;
    logic [1:0]        fail_code;
    logic [AW-1:0]     fail_addr;
    logic [2:0]        fail_pass;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [0:DEPTH-1];
    logic        stuck_en = 1'b0;
    logic        stuck_val = 1'b0;
    int          stuck_addr = 0;
    int          stuck_bit = 0;
    logic        alias_en = 1'b0;
    int          alias_bit = 0;

    int cur_words = 0;
    int wcnt = 0;
    int wbad = 0;
    int oor = 0;
    int idle_req = 0;

    always #5 clk = ~clk;

    mbist_seq #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_mbist_seq (
        .clk(clk), .rst(rst), .start(start), .bank_cnt(bank_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .busy(busy), .done(done), .fail(fail), .fail_code(fail_code),
        .fail_addr(fail_addr), .fail_pass(fail_pass)
    );

    function automatic int phys(input int a);
        return alias_en ? (a & ~(1 << alias_bit)) : a;
    endfunction

    function automatic logic [15:0] wr_pat(input int p);
        case (p)
            0: return 16'hC3C3;
            1: return 16'h0000;
            2: return 16'hFFFF;
            3: return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input int p);
        return (p == 0) ? 16'h3C3C : wr_pat(p - 1);
    endfunction

    function automatic int first_bad_pass(input int b, input logic v);
        for (int p = 0; p < 5; p++) begin
            logic [15:0] e;
            e = exp_rd(p);
            if (e[b] != v) return p;
        end
        return 5;
    endfunction

    // memory model: registered read, write on request
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[phys(int'(mem_addr))] <= mem_wdata;
            end else begin
                logic [15:0] v;
                v = mem[phys(int'(mem_addr))];
                if (stuck_en && int'(mem_addr) == stuck_addr) v[stuck_bit] = stuck_val;
                mem_rdata <= v;
            end
        end
    end

    // write stream monitor (R3, R4, R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && !busy) idle_req <= idle_req + 1;
            if (mem_req && int'(mem_addr) >= cur_words) oor <= oor + 1;
            if (mem_req && mem_we) begin
                if (cur_words > 0) begin
                    if (int'(mem_addr) != (wcnt % cur_words) || mem_wdata != wr_pat(wcnt / cur_words))
                        wbad <= wbad + 1;
                end
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic preload(input int nb);
        for (int i = 0; i < DEPTH; i++) mem[i] = (i < nb * WPB) ? 16'h3C3C : 16'hA5A5;
    endtask

    // launch and count edges after the start edge until done; err_at=0 disables mem_err
    task automatic run(input int nb, input int err_at, input bit poke, output int k);
        @(negedge clk);
        bank_cnt  = BANK_W'(nb);
        cur_words = nb * WPB;
        wcnt = 0; wbad = 0; oor = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        mem_err = (err_at == 1);
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
            mem_err = (err_at != 0) && (err_at == k + 1);
            if (poke && k == 3) bank_cnt = BANK_W'(nb == 1 ? 2 : 1);
            start = poke && (k == 5);
        end
        mem_err = 1'b0;
        start = 1'b0;
        if (k >= 3000) chk(1'b0, "watchdog run", k, 0);
    endtask

    task automatic check_success(input int nb, input int k, input string tag);
        int bad_mem;
        chk(k == 10 * nb * WPB, {tag, " R6 done time"}, k, 10 * nb * WPB);
        chk(!fail && fail_code == 2'd0 && !busy, {tag, " R6 no fail"}, int'(fail_code), 0);
        chk(wbad == 0, {tag, " R4 write stream"}, wbad, 0);
        chk(wcnt == 5 * nb * WPB, {tag, " R3 write count"}, wcnt, 5 * nb * WPB);
        chk(oor == 0, {tag, " R5 in range"}, oor, 0);
        bad_mem = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < nb * WPB && mem[i] != 16'h0000) bad_mem++;
            if (i >= nb * WPB && mem[i] != 16'hA5A5) bad_mem++;
        end
        chk(bad_mem == 0, {tag, " R6 R5 memory image"}, bad_mem, 0);
    endtask

    task automatic check_fail(input int k, input int ek, input int code, input int addr,
                              input int pass, input string tag);
        chk(k == ek, {tag, " done time"}, k, ek);
        chk(fail && fail_code == 2'(code), {tag, " code"}, int'(fail_code), code);
        chk(int'(fail_addr) == addr, {tag, " addr"}, int'(fail_addr), addr);
        chk(int'(fail_pass) == pass, {tag, " pass"}, int'(fail_pass), pass);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int k, nb, a, b, p, g, c, w;
        logic v;
        logic [AW-1:0] fa0;
        logic [1:0] fc0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mem_req && fail_code == 0 && fail_addr == 0 && fail_pass == 0,
            "R1 during reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_req, "R1 after reset", int'(busy), 0);

        // R10: zero banks
        run(0, 0, 1'b0, k);
        chk(k == 0 && done && !fail && wcnt == 0, "R10 zero banks", k, 0);

        // R6: one bank clean run, then R2: restart on zeroed memory fails at word 0
        preload(1);
        run(1, 0, 1'b0, k);
        check_success(1, k, "one bank");
        run(1, 0, 1'b0, k);
        check_fail(k, 2, 1, 0, 0, "R2 reseed restart");

        // R2: start and bank_cnt changes ignored while busy
        preload(3);
        run(3, 0, 1'b1, k);
        check_success(3, k, "R2 ignore busy inputs");

        // R9: result held, no access while idle
        fa0 = fail_addr; fc0 = fail_code; idle_req = 0;
        repeat (6) @(negedge clk);
        chk(done && fail_addr == fa0 && fail_code == fc0 && idle_req == 0, "R9 hold", idle_req, 0);

        // random clean runs
        for (int t = 0; t < 3; t++) begin
            nb = 1 + int'($urandom_range(6));
            preload(nb);
            run(nb, 0, 1'b0, k);
            check_success(nb, k, "random clean");
        end

        // R5/R7: address alias on offset bit 2 is caught in sweep 0 at address 4
        preload(2);
        alias_en = 1'b1; alias_bit = 2;
        run(2, 0, 1'b0, k);
        check_fail(k, 10, 1, 4, 0, "R7 R5 alias");
        alias_en = 1'b0;

        // R7: random stuck bits, first sweep that sees them
        for (int t = 0; t < 8; t++) begin
            nb = 1 + int'($urandom_range(6));
            a  = int'($urandom_range(nb * WPB - 1));
            b  = int'($urandom_range(15));
            v  = 1'($urandom_range(1));
            p  = first_bad_pass(b, v);
            preload(nb);
            stuck_en = 1'b1; stuck_addr = a; stuck_bit = b; stuck_val = v;
            run(nb, 0, 1'b0, k);
            g = p * nb * WPB + a;
            check_fail(k, 2 * g + 2, 1, a, p, "R7 R4 stuck bit");
            chk(wcnt == g, "R7 no write on miscompare", wcnt, g);
            stuck_en = 1'b0;
        end

        // R8: random error cycles
        for (int t = 0; t < 5; t++) begin
            nb = 1 + int'($urandom_range(6));
            c  = 1 + int'($urandom_range(10 * nb * WPB - 1));
            w  = (c - 1) / 2;
            preload(nb);
            run(nb, c, 1'b0, k);
            check_fail(k, c, 2, w % (nb * WPB), w / (nb * WPB), "R8 mem error");
        end

        // R8: error in the same compare cycle as a miscompare wins
        preload(2);
        stuck_en = 1'b1; stuck_addr = 5; stuck_bit = 0; stuck_val = 1'b1;
        run(2, 2 * 5 + 2, 1'b0, k);
        check_fail(k, 12, 2, 5, 0, "R8 priority");
        chk(wcnt == 5, "R8 write suppressed", wcnt, 5);
        stuck_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule